// File: doc/BRIEF.md
# Dual-Clock Capture Buffer with Toggle-Released Read Limit

The block captures narrow samples arriving in a converter clock domain and lets a consumer in a separate transfer clock domain read them back as wide words. Each wide word holds 2^RATIO successive samples. The first sample of a group sits in the least significant lane. The shared storage is a set of lane memories. Each lane has a write port in the sample domain and a registered read port in the transfer domain.

The writer fills the buffer once per transfer and stops at capacity. A block is 2^(2*RATIO) samples. Each time the writer completes a block, it publishes the number of completed blocks as its released address and flips a single toggle bit. The transfer domain passes that bit through a three-stage chain. A change between the last two stages is a handoff event. On a handoff event the reader latches the released count, shifted left by RATIO, as its read limit in wide words. The writer holds the released count stable for a guard window after each flip, so the latched value is always settled.

The reader returns a word only while its read address is below that limit. A transfer-start pulse clears the read address and the limit. It leaves the synchroniser chain untouched, so no stale toggle can replay the previous transfer's address.

Top module: `capbuf_top`

## Requirements
- R1: After `dma_rst`, `dma_ready_o` and `dma_valid_o` are 0 and `dma_data_o` is all zeros.
- R2: Each accepted group of 2^RATIO successive samples forms one wide word. The sample accepted first is in bits [DW-1:0], and the sample accepted k-th (k counting from 0) is in bits [k*DW +: DW]. Wide words are read back in the order they were written.
- R3: Only completed blocks of 2^(2*RATIO) samples are released. A partial block is never readable. The read limit in wide words is the released block count shifted left by RATIO.
- R4: The read address advances only while it is below the read limit (`dma_ready_o` is 1). A `dma_rd_i` pulse while `dma_ready_o` is 0 produces no word and does not move the address.
- R5: An accepted read request gives `dma_valid_o` = 1 with its word exactly one `dma_clk` cycle later. While `dma_valid_o` is 0, `dma_data_o` is zero.
- R6: The writer accepts at most 2^(RD_AW+RATIO) samples per transfer and ignores all samples after that.
- R7: The released count changes only together with a toggle flip. Two flips are at least HOLD sample-clock cycles apart. A later flip carries the latest completed block count.
- R8: A `dma_start_i` pulse clears the read address and the read limit but not the synchroniser chain. No word of an earlier transfer is returned after it.
- R9: When a handoff event and a read request fall in the same `dma_clk` cycle, the request is judged against the limit held before the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| adc_clk | input | 1 | Sample-domain clock |
| adc_rst | input | 1 | Sample-domain reset, active high; starts a new fill |
| adc_valid_i | input | 1 | Sample present this cycle |
| adc_data_i | input | DW | Sample value |
| dma_clk | input | 1 | Transfer-domain clock |
| dma_rst | input | 1 | Transfer-domain reset, active high, clears everything including the synchroniser |
| dma_start_i | input | 1 | New-transfer pulse: clears read address and limit |
| dma_rd_i | input | 1 | Read request for one wide word |
| dma_ready_o | output | 1 | A released word is available at the read address |
| dma_valid_o | output | 1 | `dma_data_o` carries a word |
| dma_data_o | output | DW*2^RATIO | Wide read word |

## Verification
The two functions that can coincide are the arrival of a handoff event and an accepted read request in the same transfer-clock cycle. The bench provokes this by holding `dma_rd_i` high for the whole time the writer is still filling the buffer. Every event then lands on a cycle that already carries a request. A scoreboard judges the result: every word must match the order of the written samples, no word may appear before its block is released, and none may appear beyond capacity. Clocked properties on the limit and the read address catch any request that the new limit admits too early.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
    // stages in the toggle chain: two for metastability, one for edge detection
    localparam int unsigned CB_SYNC_LEN = 3;
endpackage

// File: rtl/capbuf_lane_ram.sv
module capbuf_lane_ram #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 5
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/capbuf_wr.sv
module capbuf_wr #(
    parameter int unsigned RATIO = 1,
    parameter int unsigned RD_AW = 5,
    parameter int unsigned HOLD  = 8,
    localparam int unsigned LANES = 2 ** RATIO,
    localparam int unsigned NW    = RD_AW + RATIO,
    localparam int unsigned BW    = RD_AW - RATIO + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    output logic [LANES-1:0] we_o,
    output logic [RD_AW-1:0] waddr_o,
    output logic [BW-1:0]    rel_o,
    output logic             tog_o,
    output logic [NW:0]      wcnt_o
);
    localparam int unsigned HW = $clog2(HOLD + 1);
    localparam logic [NW:0] TOTAL = (NW + 1)'(1) << NW;

    typedef struct packed {
        logic [NW:0]   waddr;
        logic [BW-1:0] rel;
        logic          tog;
        logic [HW-1:0] hold;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      accept;
    logic [BW-1:0] blocks_done;

    assign accept      = valid_i && (st_q.waddr < TOTAL);
    assign blocks_done = st_q.waddr[NW:2*RATIO];

    always_comb begin
        st_d = st_q;
        if (accept) st_d.waddr = st_q.waddr + 1'b1;
        if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
        end else if (blocks_done != st_q.rel) begin
            st_d.rel  = blocks_done;
            st_d.tog  = ~st_q.tog;
            st_d.hold = HW'(HOLD - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_we
        assign we_o[l] = accept && (st_q.waddr[RATIO-1:0] == RATIO'(l));
    end

    assign waddr_o = st_q.waddr[NW-1:RATIO];
    assign rel_o   = st_q.rel;
    assign tog_o   = st_q.tog;
    assign wcnt_o  = st_q.waddr;
endmodule

// File: rtl/capbuf_tsync.sv
module capbuf_tsync
    import capbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tog_i,
    output logic evt_o
);
    typedef struct packed {
        logic [CB_SYNC_LEN-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CB_SYNC_LEN-2:0], tog_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign evt_o = st_q.chain[CB_SYNC_LEN-1] ^ st_q.chain[CB_SYNC_LEN-2];
endmodule

// File: rtl/capbuf_rd.sv
module capbuf_rd #(
    parameter int unsigned RATIO = 1,
    parameter int unsigned RD_AW = 5,
    localparam int unsigned BW = RD_AW - RATIO + 1,
    localparam int unsigned LW = RD_AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             rd_i,
    input  logic             evt_i,
    input  logic [BW-1:0]    rel_i,
    output logic             ready_o,
    output logic             re_o,
    output logic [RD_AW-1:0] raddr_o,
    output logic             valid_o,
    output logic [LW-1:0]    rcnt_o,
    output logic [LW-1:0]    lim_o
);
    typedef struct packed {
        logic [BW-1:0] rel;
        logic [LW-1:0] raddr;
        logic          valid;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [LW-1:0] lim;
    logic          take;

    assign lim     = {st_q.rel, {RATIO{1'b0}}};
    assign ready_o = st_q.raddr < lim;
    assign take    = rd_i && ready_o && !start_i;

    always_comb begin
        st_d       = st_q;
        st_d.valid = take;
        if (evt_i)        st_d.rel = rel_i;
        else if (start_i) st_d.rel = '0;
        if (start_i)      st_d.raddr = '0;
        else if (take)    st_d.raddr = st_q.raddr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign re_o    = take;
    assign raddr_o = st_q.raddr[RD_AW-1:0];
    assign valid_o = st_q.valid;
    assign rcnt_o  = st_q.raddr;
    assign lim_o   = lim;
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top #(
    parameter int unsigned DW    = 16,
    parameter int unsigned RATIO = 1,
    parameter int unsigned RD_AW = 5,
    parameter int unsigned HOLD  = 8
) (
    input  logic                      adc_clk,
    input  logic                      adc_rst,
    input  logic                      adc_valid_i,
    input  logic [DW-1:0]             adc_data_i,
    input  logic                      dma_clk,
    input  logic                      dma_rst,
    input  logic                      dma_start_i,
    input  logic                      dma_rd_i,
    output logic                      dma_ready_o,
    output logic                      dma_valid_o,
    output logic [DW*(2**RATIO)-1:0]  dma_data_o
);
    localparam int unsigned LANES = 2 ** RATIO;
    localparam int unsigned NW    = RD_AW + RATIO;
    localparam int unsigned BW    = RD_AW - RATIO + 1;
    localparam int unsigned LW    = RD_AW + 1;

    logic [LANES-1:0]    lane_we;
    logic [RD_AW-1:0]    wr_waddr;
    logic [BW-1:0]       adc_rel;
    logic                adc_tog;
    logic [NW:0]         adc_wcnt;
    logic                dma_evt;
    logic                rd_re;
    logic [RD_AW-1:0]    rd_raddr;
    logic [LW-1:0]       dma_rcnt;
    logic [LW-1:0]       dma_lim;
    logic [DW*LANES-1:0] lane_q;

    capbuf_wr #(.RATIO(RATIO), .RD_AW(RD_AW), .HOLD(HOLD)) u_wr (
        .clk     (adc_clk),
        .rst     (adc_rst),
        .valid_i (adc_valid_i),
        .we_o    (lane_we),
        .waddr_o (wr_waddr),
        .rel_o   (adc_rel),
        .tog_o   (adc_tog),
        .wcnt_o  (adc_wcnt)
    );

    capbuf_tsync u_sync (
        .clk   (dma_clk),
        .rst   (dma_rst),
        .tog_i (adc_tog),
        .evt_o (dma_evt)
    );

    capbuf_rd #(.RATIO(RATIO), .RD_AW(RD_AW)) u_rd (
        .clk     (dma_clk),
        .rst     (dma_rst),
        .start_i (dma_start_i),
        .rd_i    (dma_rd_i),
        .evt_i   (dma_evt),
        .rel_i   (adc_rel),
        .ready_o (dma_ready_o),
        .re_o    (rd_re),
        .raddr_o (rd_raddr),
        .valid_o (dma_valid_o),
        .rcnt_o  (dma_rcnt),
        .lim_o   (dma_lim)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        capbuf_lane_ram #(.DW(DW), .AW(RD_AW)) u_ram (
            .wclk  (adc_clk),
            .we    (lane_we[l]),
            .waddr (wr_waddr),
            .wdata (adc_data_i),
            .rclk  (dma_clk),
            .re    (rd_re),
            .raddr (rd_raddr),
            .rdata (lane_q[l*DW +: DW])
        );
    end

    assign dma_data_o = dma_valid_o ? lane_q : '0;
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
    parameter int unsigned DW    = 16,
    parameter int unsigned RATIO = 1,
    parameter int unsigned RD_AW = 5,
    localparam int unsigned LANES = 2 ** RATIO,
    localparam int unsigned NW    = RD_AW + RATIO,
    localparam int unsigned BW    = RD_AW - RATIO + 1,
    localparam int unsigned LW    = RD_AW + 1
) (
    input logic                adc_clk,
    input logic                adc_rst,
    input logic                dma_clk,
    input logic                dma_rst,
    input logic                dma_start_i,
    input logic                dma_rd_i,
    input logic                dma_valid_o,
    input logic [DW*LANES-1:0] dma_data_o,
    input logic [NW:0]         adc_wcnt,
    input logic [BW-1:0]       adc_rel,
    input logic                adc_tog,
    input logic                dma_evt,
    input logic [LW-1:0]       dma_rcnt,
    input logic [LW-1:0]       dma_lim
);
    localparam logic [NW:0]   TOTAL   = (NW + 1)'(1) << NW;
    localparam logic [BW-1:0] MAX_BLK = BW'(2 ** (RD_AW - RATIO));

    AST_NO_OVERFLOW: assert property (@(posedge adc_clk) disable iff (adc_rst)
        adc_wcnt <= TOTAL); // R6

    AST_REL_BOUND: assert property (@(posedge adc_clk) disable iff (adc_rst)
        adc_rel <= MAX_BLK); // R3

    AST_REL_HOLD: assert property (@(posedge adc_clk) disable iff (adc_rst)
        (adc_tog == $past(adc_tog)) |-> $stable(adc_rel)); // R7

    AST_LIM_LATCH: assert property (@(posedge dma_clk) disable iff (dma_rst)
        dma_evt |=> dma_lim == (LW'($past(adc_rel)) << RATIO)); // R3

    AST_LIM_STABLE: assert property (@(posedge dma_clk) disable iff (dma_rst)
        (!dma_evt && !dma_start_i) |=> $stable(dma_lim)); // R8

    AST_READ_GATED: assert property (@(posedge dma_clk) disable iff (dma_rst)
        (dma_rd_i && !dma_start_i && dma_rcnt >= dma_lim)
        |=> (!dma_valid_o && $stable(dma_rcnt))); // R4

    AST_READ_ADVANCE: assert property (@(posedge dma_clk) disable iff (dma_rst)
        (dma_rd_i && !dma_start_i && dma_rcnt < dma_lim)
        |=> (dma_valid_o && dma_rcnt == LW'($past(dma_rcnt) + 1'b1))); // R9

    AST_START_CLEAR: assert property (@(posedge dma_clk) disable iff (dma_rst)
        dma_start_i |=> dma_rcnt == '0); // R8

    AST_DATA_IDLE: assert property (@(posedge dma_clk) disable iff (dma_rst)
        !dma_valid_o |-> dma_data_o == '0); // R5
endmodule

bind capbuf_top capbuf_chk #(.DW(DW), .RATIO(RATIO), .RD_AW(RD_AW)) u_chk (
    .adc_clk     (adc_clk),
    .adc_rst     (adc_rst),
    .dma_clk     (dma_clk),
    .dma_rst     (dma_rst),
    .dma_start_i (dma_start_i),
    .dma_rd_i    (dma_rd_i),
    .dma_valid_o (dma_valid_o),
    .dma_data_o  (dma_data_o),
    .adc_wcnt    (adc_wcnt),
    .adc_rel     (adc_rel),
    .adc_tog     (adc_tog),
    .dma_evt     (dma_evt),
    .dma_rcnt    (dma_rcnt),
    .dma_lim     (dma_lim)
);

// File: tb/tb_capbuf_top.sv
module tb_capbuf_top;
    localparam int unsigned DW    = 16;
    localparam int unsigned RATIO = 1;
    localparam int unsigned RD_AW = 5;
    localparam int unsigned HOLD  = 8;
    localparam int unsigned LANES = 2 ** RATIO;
    localparam int unsigned TOTAL = 2 ** (RD_AW + RATIO);

    logic adc_clk = 1'b0;
    logic dma_clk = 1'b0;
    logic adc_rst, adc_valid_i, dma_rst, dma_start_i, dma_rd_i;
    logic [DW-1:0] adc_data_i;
    logic dma_ready_o, dma_valid_o;
    logic [DW*LANES-1:0] dma_data_o;

    always #10 dma_clk = ~dma_clk;   // 50 MHz
    always #7  adc_clk = ~adc_clk;

    capbuf_top #(.DW(DW), .RATIO(RATIO), .RD_AW(RD_AW), .HOLD(HOLD)) dut (
        .adc_clk(adc_clk), .adc_rst(adc_rst), .adc_valid_i(adc_valid_i),
        .adc_data_i(adc_data_i), .dma_clk(dma_clk), .dma_rst(dma_rst),
        .dma_start_i(dma_start_i), .dma_rd_i(dma_rd_i),
        .dma_ready_o(dma_ready_o), .dma_valid_o(dma_valid_o),
        .dma_data_o(dma_data_o)
    );

    int checks = 0;
    int failures = 0;
    int received = 0;
    int wr_cnt = 0;
    logic [DW-1:0] sample = 16'h1000;
    logic [DW*LANES-1:0] acc;
    logic [DW*LANES-1:0] exp_q[$];
    logic mon_en = 1'b0;
    logic finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: writes samples and pushes expected wide words (R2, R6)
    task automatic adc_write(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge adc_clk);
            adc_valid_i = 1'b1;
            adc_data_i  = sample;
            if (wr_cnt < TOTAL) begin
                acc[(wr_cnt % LANES)*DW +: DW] = sample;
                if ((wr_cnt % LANES) == LANES - 1) exp_q.push_back(acc);
            end
            wr_cnt++;
            sample++;
        end
        @(negedge adc_clk);
        adc_valid_i = 1'b0;
    endtask

    task automatic read_words(input int n);
        int got = 0;
        int guard = 0;
        while (got < n && guard < 2000) begin
            @(negedge dma_clk);
            if (dma_ready_o) begin
                dma_rd_i = 1'b1;
                got++;
            end else begin
                dma_rd_i = 1'b0;
            end
            guard++;
        end
        @(negedge dma_clk);
        dma_rd_i = 1'b0;
        check(got == n, "R3 words released", 64'(got), 64'(n));
    endtask

    task automatic dma_wait(input int n);
        repeat (n) @(negedge dma_clk);
    endtask

    // monitor: pops and compares as words appear (R2, R5, R4)
    always @(negedge dma_clk) begin
        if (mon_en) begin
            if (dma_valid_o) begin
                received++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 word without release", 64'(dma_data_o), 64'd0);
                end else begin
                    check(dma_data_o == exp_q[0], "R2 word content/order",
                          64'(dma_data_o), 64'(exp_q[0]));
                    void'(exp_q.pop_front());
                end
            end else begin
                check(dma_data_o == '0, "R5 idle data zero", 64'(dma_data_o), 64'd0);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        adc_rst = 1'b1; dma_rst = 1'b1; adc_valid_i = 1'b0; adc_data_i = '0;
        dma_start_i = 1'b0; dma_rd_i = 1'b0; acc = '0;
        dma_wait(6);
        adc_rst = 1'b0;
        dma_rst = 1'b0;
        dma_wait(1);
        // R1
        check(dma_ready_o == 1'b0, "R1 ready after reset", 64'(dma_ready_o), 64'd0);
        check(dma_valid_o == 1'b0, "R1 valid after reset", 64'(dma_valid_o), 64'd0);
        check(dma_data_o == '0, "R1 data after reset", 64'(dma_data_o), 64'd0);
        mon_en = 1'b1;

        // one block, then read its two wide words (R2, R3, R5)
        adc_write(4);
        read_words(2);
        dma_wait(3);
        check(exp_q.size() == 0, "R2 block drained", 64'(exp_q.size()), 64'd0);

        // request while nothing released: ignored (R4)
        dma_rd_i = 1'b1;
        dma_wait(3);
        dma_rd_i = 1'b0;
        dma_wait(2);
        check(received == 2, "R4 request ignored", 64'(received), 64'd2);

        // partial block stays hidden (R3)
        adc_write(3);
        dma_wait(30);
        check(dma_ready_o == 1'b0, "R3 partial block hidden", 64'(dma_ready_o), 64'd0);

        // two blocks finish close together: later flip carries latest count (R7)
        adc_write(5);
        read_words(4);
        dma_wait(3);
        check(received == 6, "R7 latest count released", 64'(received), 64'd6);
        check(exp_q.size() == 0, "R7 queue drained", 64'(exp_q.size()), 64'd0);

        // request held high while writer fills past capacity (R9, R6)
        dma_rd_i = 1'b1;
        adc_write(TOTAL - 12 + 5);
        dma_wait(60);
        dma_rd_i = 1'b0;
        dma_wait(3);
        check(received == TOTAL / LANES, "R6 capacity word count",
              64'(received), 64'(TOTAL / LANES));
        check(exp_q.size() == 0, "R9 all words matched", 64'(exp_q.size()), 64'd0);
        check(dma_ready_o == 1'b0, "R6 nothing beyond capacity", 64'(dma_ready_o), 64'd0);

        // new transfer: start pulse, no replay of the old address (R8)
        @(negedge dma_clk);
        dma_start_i = 1'b1;
        @(negedge dma_clk);
        dma_start_i = 1'b0;
        dma_wait(10);
        check(dma_ready_o == 1'b0, "R8 no replay after start", 64'(dma_ready_o), 64'd0);
        @(negedge adc_clk);
        adc_rst = 1'b1;
        repeat (6) @(negedge adc_clk);
        adc_rst = 1'b0;
        wr_cnt = 0;
        dma_wait(10);
        check(dma_ready_o == 1'b0, "R8 writer reset releases nothing",
              64'(dma_ready_o), 64'd0);
        adc_write(4);
        read_words(2);
        dma_wait(3);
        check(received == TOTAL / LANES + 2, "R8 fresh transfer words",
              64'(received), 64'(TOTAL / LANES + 2));
        check(exp_q.size() == 0, "R8 fresh data matched", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule